// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Encoder

This block converts the transmit nibble stream of a 100 Mb/s media-independent interface into ternary line symbols for a twisted-pair driver. It runs on the 125 MHz symbol clock and produces its own nibble strobe, one cycle in five. The inputs are sampled on the edge where the strobe is high. Each nibble slot becomes one 5-bit code group. The block inserts the start and end delimiters around a frame, substitutes the halt group on a transmit error, and sends the idle group when no frame is active.

Each code group is shifted out most significant bit first. The bits are whitened by an additive scrambler built on an 11-bit LFSR and then folded into a three-level MLT-3 waveform. The result goes out as a 2-bit signed code to the external analog stage.

A bypass path serves test equipment and external coders. When auto-negotiation is off and either the bypass pin or the bypass configuration bit is set, the error line and the data nibble together form a raw 5-bit group. That group goes straight to the serializer, unscrambled, and the enable line has no effect.

Top module: `fx_tx_pcs`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `line` is 0 (code 2'b00) and `nib_tick` is high. The framing state starts in idle.
- R2: `nib_tick` is high for exactly one cycle in every 5. The block samples `tx_en`, `tx_er`, `txd` and the bypass controls at the clock edge that ends a cycle in which `nib_tick` is high.
- R3: In the data state, a nibble with `tx_er` low is sent as its 4B/5B group (0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101).
- R4: The first slot with `tx_en` high after idle is sent as J (11000). The next slot is sent as K (10001) whatever the inputs are. The data state follows.
- R5: The first slot in the data state with `tx_en` low is sent as T (01101). The next slot is sent as R (00111). The framing state then returns to idle.
- R6: In the data state, a slot with both `tx_en` and `tx_er` high is sent as the halt group H (00100).
- R7: In the idle state, a slot with `tx_en` low is sent as the idle group I (11111).
- R8: Each group is serialized most significant bit first, one bit per clock. Every serial bit is XORed with the key bit k, where k[n] = k[n-11] XOR k[n-9] (polynomial x^11+x^9+1). The LFSR advances every clock from the nonzero SEED and its state is never zero.
- R9: The line level steps through the cycle 0, +1, 0, -1 on each serial 1 and holds on each serial 0. The codes are 2'b00 for 0, 2'b01 for +1 and 2'b11 for -1, and 2'b10 never appears.
- R10: Bypass is active when (`byp_pin` OR `byp_cfg`) AND NOT `an_enable`. The slot's group is then {`tx_er`,`txd[3:0]`}, with `tx_er` as the MSB, sent without scrambling. `tx_en` is ignored, and the framing state returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error; MSB of the raw group in bypass |
| txd | input | 4 | Transmit data nibble |
| byp_pin | input | 1 | Bypass request from a strap pin |
| byp_cfg | input | 1 | Bypass request from a configuration bit |
| an_enable | input | 1 | Auto-negotiation enabled; blocks bypass |
| nib_tick | output | 1 | Nibble strobe, high one cycle in five |
| line | output | 2 | Signed ternary symbol for the line driver |

## Verification
The bench builds the block with SEED = 11'h5A3 rather than the default. It never reads that value. Instead it recovers the key stream from the line during the leading idle groups and extends it with the polynomial recurrence. This shows that the output depends only on the scrambler polynomial and the seed's nonzero start, and that every later group, scrambled or bypassed, can be decoded bit-exactly. SCR_EN stays at 1 so that the scrambling path is the one under test. The pass-through variant differs only in the key bit.

// File: rtl/fx_pcs_pkg.sv
package fx_pcs_pkg;

   localparam int NIB_W = 4;
   localparam int GRP_W = 5;

   localparam logic [GRP_W-1:0] CG_IDLE = 5'b11111;
   localparam logic [GRP_W-1:0] CG_J    = 5'b11000;
   localparam logic [GRP_W-1:0] CG_K    = 5'b10001;
   localparam logic [GRP_W-1:0] CG_T    = 5'b01101;
   localparam logic [GRP_W-1:0] CG_R    = 5'b00111;
   localparam logic [GRP_W-1:0] CG_HALT = 5'b00100;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_SOK  = 2'd1,
      FR_DATA = 2'd2,
      FR_EOR  = 2'd3
   } frame_st_e;

   localparam logic [1:0] LV_ZERO = 2'b00;
   localparam logic [1:0] LV_POS  = 2'b01;
   localparam logic [1:0] LV_NEG  = 2'b11;

   function automatic logic [GRP_W-1:0] nib_to_grp(input logic [NIB_W-1:0] n);
      logic [GRP_W-1:0] g;
      case (n)
         4'h0: g = 5'b11110;
         4'h1: g = 5'b01001;
         4'h2: g = 5'b10100;
         4'h3: g = 5'b10101;
         4'h4: g = 5'b01010;
         4'h5: g = 5'b01011;
         4'h6: g = 5'b01110;
         4'h7: g = 5'b01111;
         4'h8: g = 5'b10010;
         4'h9: g = 5'b10011;
         4'hA: g = 5'b10110;
         4'hB: g = 5'b10111;
         4'hC: g = 5'b11010;
         4'hD: g = 5'b11011;
         4'hE: g = 5'b11100;
         default: g = 5'b11101;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/fx_tx_framer.sv
module fx_tx_framer
   import fx_pcs_pkg::*;
#(
   parameter int NW = NIB_W,
   parameter int GW = GRP_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          byp,
   input  logic          tx_en,
   input  logic          tx_er,
   input  logic [NW-1:0] txd,
   output logic [GW-1:0] grp
);

   generate
      if (GW != NW + 1) begin : g_bad_w
         $error("group width must be nibble width plus one");
      end
   endgenerate

   frame_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      grp  = CG_IDLE;
      if (byp) begin
         grp  = {tx_er, txd};
         st_d = FR_IDLE;
      end else begin
         case (st_q)
            FR_IDLE: begin
               if (tx_en) begin
                  grp  = CG_J;
                  st_d = FR_SOK;
               end
            end
            FR_SOK: begin
               grp  = CG_K;
               st_d = FR_DATA;
            end
            FR_DATA: begin
               if (!tx_en) begin
                  grp  = CG_T;
                  st_d = FR_EOR;
               end else if (tx_er) begin
                  grp = CG_HALT;
               end else begin
                  grp = nib_to_grp(txd);
               end
            end
            default: begin
               grp  = CG_R;
               st_d = FR_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st_q <= FR_IDLE;
      else if (load) st_q <= st_d;
   end

   AST_K_FOLLOWS_J: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !byp && grp == CG_J) |=> st_q == FR_SOK);   // R4
   AST_R_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !byp && grp == CG_R) |=> st_q == FR_IDLE);  // R5
   AST_BYP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (load && byp) |=> st_q == FR_IDLE);                   // R10
   AST_HOLD_OFF_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(st_q));                             // R2

endmodule

// File: rtl/fx_tx_scrambler.sv
module fx_tx_scrambler #(
   parameter int           LW     = 11,
   parameter int           TAP    = 9,
   parameter logic [LW-1:0] SEED  = 11'h7FF,
   parameter bit           SCR_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_in,
   input  logic pass,
   output logic bit_out
);

   generate
      if (TAP < 1 || TAP >= LW) begin : g_bad_tap
         $error("scrambler tap must lie inside the register");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("scrambler seed must be nonzero");
      end
   endgenerate

   logic [LW-1:0] lfsr_q;
   logic          key;

   assign key = lfsr_q[LW-1] ^ lfsr_q[TAP-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lfsr_q <= SEED;
      else        lfsr_q <= {lfsr_q[LW-2:0], key};
   end

   generate
      if (SCR_EN) begin : g_scr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_out <= 1'b0;
            else        bit_out <= pass ? bit_in : (bit_in ^ key);
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_out <= 1'b0;
            else        bit_out <= bit_in;
         end
      end
   endgenerate

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != '0);                                        // R8
   AST_PASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      pass |=> bit_out == $past(bit_in));                   // R10

endmodule

// File: rtl/fx_tx_mlt3.sv
module fx_tx_mlt3
   import fx_pcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_in,
   output logic [1:0] line
);

   logic [1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ph_q <= 2'd0;
      else if (bit_in) ph_q <= ph_q + 2'd1;
   end

   always_comb begin
      case (ph_q)
         2'd1:    line = LV_POS;
         2'd3:    line = LV_NEG;
         default: line = LV_ZERO;
      endcase
   end

   AST_MLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_in |=> $stable(line));                           // R9
   AST_MLT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      bit_in |=> line != $past(line));                      // R9
   AST_LINE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      line != 2'b10);                                       // R9

endmodule

// File: rtl/fx_tx_pcs.sv
module fx_tx_pcs
   import fx_pcs_pkg::*;
#(
   parameter int          LFSR_W = 11,
   parameter int          LFSR_TAP = 9,
   parameter logic [10:0] SEED   = 11'h7FF,
   parameter bit          SCR_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en,
   input  logic       tx_er,
   input  logic [3:0] txd,
   input  logic       byp_pin,
   input  logic       byp_cfg,
   input  logic       an_enable,
   output logic       nib_tick,
   output logic [1:0] line
);

   localparam int PH_W = $clog2(GRP_W);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(GRP_W - 1);

   generate
      if (LFSR_W != 11) begin : g_bad_lw
         $error("seed port width fixes the register at 11 bits");
      end
   endgenerate

   logic [PH_W-1:0]  ph_q;
   logic             load;
   logic             byp_now;
   logic             byp_grp_q;
   logic [GRP_W-1:0] grp;
   logic [GRP_W-1:0] sh_q;
   logic             plain_bit;
   logic             scr_bit;

   assign load     = (ph_q == '0);
   assign nib_tick = load;
   assign byp_now  = (byp_pin | byp_cfg) & ~an_enable;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ph_q <= '0;
      else if (ph_q == PH_LAST) ph_q <= '0;
      else                     ph_q <= ph_q + 1'b1;
   end

   fx_tx_framer #(.NW(NIB_W), .GW(GRP_W)) u_framer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .byp   (byp_now),
      .tx_en (tx_en),
      .tx_er (tx_er),
      .txd   (txd),
      .grp   (grp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= CG_IDLE;
         byp_grp_q <= 1'b0;
      end else if (load) begin
         sh_q      <= grp;
         byp_grp_q <= byp_now;
      end else begin
         sh_q      <= {sh_q[GRP_W-2:0], 1'b1};
      end
   end

   assign plain_bit = sh_q[GRP_W-1];

   fx_tx_scrambler #(
      .LW     (LFSR_W),
      .TAP    (LFSR_TAP),
      .SEED   (SEED),
      .SCR_EN (SCR_EN)
   ) u_scr (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_in  (plain_bit),
      .pass    (byp_grp_q),
      .bit_out (scr_bit)
   );

   fx_tx_mlt3 u_mlt3 (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_in (scr_bit),
      .line   (line)
   );

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      nib_tick |=> !nib_tick);                              // R2
   AST_BYP_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      !nib_tick |=> $stable(byp_grp_q));                    // R10

endmodule

// File: tb/tb_fx_tx_pcs.sv
module tb_fx_tx_pcs;

   localparam int CLK_PERIOD = 10;
   localparam int MAXG = 2048;
   localparam int MAXB = MAXG * 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0, tx_er = 1'b0;
   logic [3:0] txd = 4'h0;
   logic       byp_pin = 1'b0, byp_cfg = 1'b0, an_enable = 1'b0;
   logic       nib_tick;
   logic [1:0] line;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [4:0] exp_grp [MAXG];
   bit         exp_byp [MAXG];
   string      exp_req [MAXG];
   int         nslots = 0;
   int         mst = 0;     // bench frame state: 0 idle, 1 K next, 2 data, 3 R next

   always #(CLK_PERIOD/2) clk = ~clk;

   fx_tx_pcs #(.SEED(11'h5A3)) dut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
      .byp_pin(byp_pin), .byp_cfg(byp_cfg), .an_enable(an_enable),
      .nib_tick(nib_tick), .line(line)
   );

   function automatic logic [4:0] enc_ref(input logic [3:0] n);
      logic [4:0] t [16];
      t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
            5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
            5'b11010, 5'b11011, 5'b11100, 5'b11101};
      return t[n];
   endfunction

   function automatic logic [1:0] lvl_ref(input int ph);
      case (ph % 4)
         1: return 2'b01;
         3: return 2'b11;
         default: return 2'b00;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // expected group for one slot, from the requirements
   task automatic model(input bit en, input bit er, input logic [3:0] d,
                        input bit pin, input bit cfg, input bit an);
      bit b;
      b = (pin | cfg) & ~an;
      exp_byp[nslots] = b;
      if (b) begin
         exp_grp[nslots] = {er, d}; exp_req[nslots] = "R10"; mst = 0;
      end else begin
         case (mst)
            0: if (en) begin exp_grp[nslots] = 5'b11000; exp_req[nslots] = "R4"; mst = 1; end
               else begin exp_grp[nslots] = 5'b11111; exp_req[nslots] = "R7"; end
            1: begin exp_grp[nslots] = 5'b10001; exp_req[nslots] = "R4"; mst = 2; end
            2: if (!en) begin exp_grp[nslots] = 5'b01101; exp_req[nslots] = "R5"; mst = 3; end
               else if (er) begin exp_grp[nslots] = 5'b00100; exp_req[nslots] = "R6"; end
               else begin exp_grp[nslots] = enc_ref(d); exp_req[nslots] = "R3"; end
            default: begin exp_grp[nslots] = 5'b00111; exp_req[nslots] = "R5"; mst = 0; end
         endcase
      end
      nslots++;
   endtask

   task automatic slot(input bit en, input bit er, input logic [3:0] d,
                       input bit pin, input bit cfg, input bit an);
      do @(negedge clk); while (!nib_tick);
      tx_en = en; tx_er = er; txd = d; byp_pin = pin; byp_cfg = cfg; an_enable = an;
      if (nslots < MAXG) model(en, er, d, pin, cfg, an);
   endtask

   // line monitor: bit recovery, MLT-3 order, self-synchronised descrambling
   int         ecnt = 0;
   int         mph = 0;
   logic [1:0] prev_l = 2'b00;
   bit         kst [MAXB];
   logic [4:0] acc = '0;
   int         tick_gap = 0;
   bit         tick_seen = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         ecnt = 0; mph = 0; prev_l = 2'b00; tick_gap = 0; tick_seen = 1'b0;
      end else if (!done) begin
         bit s, key, p;
         int n, g, j;
         s = (line != prev_l);
         if (s) mph++;
         // R9: each change moves to the next level of 0,+1,0,-1
         check(line == lvl_ref(mph), "R9", line, lvl_ref(mph));
         if (ecnt >= 2 && ecnt - 2 < MAXB) begin
            n = ecnt - 2; g = n / 5; j = n % 5;
            if (n < 22) key = s ^ 1'b1;
            else        key = kst[n-11] ^ kst[n-9];
            kst[n] = key;
            p = exp_byp[g] ? s : (s ^ key);
            acc = {acc[3:0], p};
            if (j == 4 && g >= 5 && g < nslots)
               check(acc == exp_grp[g], exp_req[g], acc, exp_grp[g]);  // R8 serial order and key
         end
         // R2: strobe spacing
         if (nib_tick) begin
            if (tick_seen) check(tick_gap == 5, "R2", tick_gap, 5);
            tick_seen = 1'b1; tick_gap = 1;
         end else tick_gap++;
         prev_l = line;
         ecnt++;
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'h1F2E));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(line == 2'b00, "R1", line, 0);
      check(nib_tick == 1'b1, "R1", nib_tick, 1);
      #2 rst_n = 1'b1;
      model(1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);   // slot 0 loads idle inputs
      @(negedge clk);
      check(line == 2'b00, "R1", line, 0);
      repeat (6) slot(0, 0, 4'h0, 0, 0, 0);                 // R7
      // R3 R4 R5: full frame walking every nibble
      for (int i = 0; i < 18; i++) slot(1, 0, 4'(i), 0, 0, 0);
      repeat (3) slot(0, 0, 4'h0, 0, 0, 0);
      // one-slot frame: J, K, T, R
      slot(1, 0, 4'h5, 0, 0, 0);
      repeat (4) slot(0, 1, 4'hA, 0, 0, 0);
      // R6: halt in data, error ignored during J and K
      slot(1, 1, 4'h3, 0, 0, 0); slot(1, 1, 4'h3, 0, 0, 0);
      slot(1, 0, 4'h9, 0, 0, 0); slot(1, 1, 4'h9, 0, 0, 0);
      slot(1, 0, 4'hC, 0, 0, 0);
      repeat (3) slot(0, 0, 4'h0, 0, 0, 0);
      // R10: bypass blocked by auto-negotiation
      repeat (4) slot(0, 1, 4'h1, 1, 0, 1);
      // R10: bypass by pin, then by cfg, enable toggling and entry mid-frame
      for (int i = 0; i < 12; i++) slot(i[0], i[1], 4'(i * 3), 1, 0, 0);
      slot(1, 0, 4'h2, 0, 0, 0); slot(1, 0, 4'h2, 0, 0, 0); slot(1, 0, 4'h7, 0, 0, 0);
      for (int i = 0; i < 12; i++) slot(i[1], i[0], 4'(15 - i), 0, 1, 0);
      repeat (3) slot(0, 0, 4'h0, 0, 0, 0);
      // constrained random frames
      for (int i = 0; i < 600; i++) begin
         int r;
         bit en, er, pin, cfg, an;
         r   = $urandom_range(0, 99);
         en  = (r < 70);
         er  = ($urandom_range(0, 19) == 0);
         pin = ($urandom_range(0, 29) == 0);
         cfg = ($urandom_range(0, 29) == 0);
         an  = ($urandom_range(0, 3) == 0);
         slot(en, er, 4'($urandom_range(0, 15)), pin, cfg, an);
      end
      repeat (6) slot(0, 0, 4'h0, 0, 0, 0);
      repeat (20) @(negedge clk);
      finish_run();
   end

endmodule